// File: doc/BRIEF.md
# Hardware Store Request Controller

This block is the control core of a battery-free nonvolatile SRAM that copies its volatile array into nonvolatile cells on request. A single active-low pin carries the request inward and, as an open-drain pull-down, carries the busy indication outward. The block samples that pin through a synchronizer and opens a grace window when it sees the pin fall. During the window reads keep flowing and a write already under way may finish. Any write that begins after the request is refused.

At the end of the window a store is launched only if the array holds data written since the last store or recall. While any store runs, including one started by another source, the block pulls the pin low, disables the array and blocks writes. After the store it keeps the array disabled until the pin is seen high again. Write completions are tracked by a dirty flag, which is cleared when a store finishes or when a recall-done indication arrives. Delays are counted in clock cycles.

Top module: `nv_store_ctrl`

## Requirements
- R1: After reset, `busy_drive_o`, `write_inhibit_o`, `disable_o` and `store_start_o` are 0, and accesses are granted: `write_grant_o` = `ce_i & we_i`, `read_grant_o` = `ce_i & rd_i`.
- R2: While `req_pin_i` stays 1 (idle or unconnected), no store is launched and every combination of `ce_i`, `we_i` and `rd_i` is granted as in R1.
- R3: The third rising clock edge after `req_pin_i` falls starts a grace window of `DELAY_CYCLES` cycles. From that edge on, `write_inhibit_o` is 1, except for a write covered by R4. Reads stay granted throughout the window.
- R4: A write whose strobe (`ce_i & we_i`) is high at the edge that opens the window stays granted until its strobe drops. Any other write is refused from the window start until the block returns to idle.
- R5: If the array is dirty when the window ends, then from edge 3+`DELAY_CYCLES` after the pin fall `busy_drive_o` and `disable_o` are 1, and `store_start_o` is 1 for exactly one cycle.
- R6: If the array is clean when the window ends, no store is launched: busy, disable and start stay 0. Writes stay refused until the pin is seen high again.
- R7: `busy_drive_o` stays 1 until an edge samples `store_done_i` = 1, and drops right after that edge.
- R8: After a store ends, `disable_o` stays 1 until the pin level has been sampled high on three consecutive edges. When the external pin is already high, this means it drops after the fourth edge.
- R9: The dirty flag is set when a granted write strobe ends, including a write that finishes inside the grace window. It is cleared when a store completes and when `recall_done_i` is 1. A request that finds no write since the last clear launches nothing.
- R10: An `ext_store_i` pulse in idle marks a store run by another source. From the next edge `busy_drive_o`, `disable_o` and `write_inhibit_o` are 1 and `store_start_o` stays 0. The store ends on `store_done_i` like any other. `ext_store_i` is ignored outside idle.
- R11: The pin level seen by the block is `req_pin_i & ~busy_drive_o`, so the block's own pull-down never raises a hardware request.
- R12: `store_done_i` has no effect outside a running store. In particular it neither changes the outputs nor clears the dirty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_pin_i | input | 1 | External level of the request/busy pin, 1 when released |
| ce_i | input | 1 | Chip enable strobe |
| we_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| ext_store_i | input | 1 | Pulse: another source has started a store |
| store_done_i | input | 1 | Store cycle timer finished |
| recall_done_i | input | 1 | Recall finished, array now clean |
| busy_drive_o | output | 1 | Open-drain pull-down enable for the pin |
| write_inhibit_o | output | 1 | New writes are blocked |
| disable_o | output | 1 | Array disabled for all accesses |
| store_start_o | output | 1 | One-cycle pulse that starts the store timer |
| write_grant_o | output | 1 | Write strobe passed to the array |
| read_grant_o | output | 1 | Read strobe passed to the array |

## Verification
Three edges separate a pin fall from the window opening, so the bench samples `write_inhibit_o` after edge two, where it must still be 0, and after edge three, where it must be 1. The store pulse is due after edge 3+`DELAY_CYCLES`. `busy_drive_o` drops one edge after `store_done_i` is sampled. `disable_o` releases on the fourth edge after the pin level is high, and the bench checks it both one edge early and on time. All checks are taken 1 ns after a rising edge, once the inputs for that cycle are applied. Grant outputs are combinational and are checked in the same cycle as their strobes.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRACE,
    ST_STORE,
    ST_HOLD,
    ST_BLOCK
  } nvs_state_e;
endpackage

// File: rtl/nvs_pin_sync.sv
module nvs_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic fall_o,
  output logic all_high_o
);
  localparam int SW = SYNC_STAGES + 1;

  logic [SW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[SW-2:0], level_i};
  end

  // fall seen on the synchronized copy; all_high means no pending low in the chain
  assign fall_o     = sh_q[SW-1] & ~sh_q[SW-2];
  assign all_high_o = &sh_q;
endmodule

// File: rtl/nvs_dirty_track.sv
module nvs_dirty_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_grant_i,
  input  logic clear_i,
  output logic dirty_o,
  output logic set_o
);
  logic grant_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
      dirty_o <= 1'b0;
    end else begin
      grant_q <= wr_grant_i;
      if (set_o)        dirty_o <= 1'b1;
      else if (clear_i) dirty_o <= 1'b0;
    end
  end

  assign set_o = grant_q & ~wr_grant_i;

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i && !set_o) |-> !dirty_o);
  assert_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(set_o) |-> dirty_o);
endmodule

// File: rtl/nvs_store_fsm.sv
module nvs_store_fsm
  import nvs_pkg::*;
#(
  parameter int DELAY_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic pin_high_i,
  input  logic ext_store_i,
  input  logic store_done_i,
  input  logic wr_req_i,
  input  logic dirty_i,
  input  logic dirty_set_i,
  output logic busy_drive_o,
  output logic disable_o,
  output logic write_inhibit_o,
  output logic store_start_o,
  output logic store_end_o
);
  localparam int CW = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

  nvs_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic carry_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ext_store_i)  state_d = ST_STORE;
        else if (fall_i)  state_d = ST_GRACE;
      end
      ST_GRACE: begin
        if (cnt_q == LAST) state_d = (dirty_i | dirty_set_i) ? ST_STORE : ST_BLOCK;
      end
      ST_STORE: if (store_done_i) state_d = ST_HOLD;
      ST_HOLD,
      ST_BLOCK: if (pin_high_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      carry_q       <= 1'b0;
      store_start_o <= 1'b0;
    end else begin
      state_q       <= state_d;
      cnt_q         <= (state_q == ST_GRACE && state_d == ST_GRACE) ? cnt_q + 1'b1 : '0;
      store_start_o <= (state_q == ST_GRACE) && (state_d == ST_STORE);
      // a write live at window entry may run on until its strobe drops
      if (state_q == ST_IDLE && state_d == ST_GRACE)
        carry_q <= wr_req_i;
      else if (state_q == ST_GRACE && state_d == ST_GRACE)
        carry_q <= carry_q & wr_req_i;
      else
        carry_q <= 1'b0;
    end
  end

  assign busy_drive_o    = (state_q == ST_STORE);
  assign disable_o       = (state_q == ST_STORE) || (state_q == ST_HOLD);
  assign write_inhibit_o = (state_q != ST_IDLE) && !carry_q;
  assign store_end_o     = (state_q == ST_STORE) && store_done_i;

  assert_start_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |=> !store_start_o);
  assert_start_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |-> busy_drive_o && disable_o);
  assert_busy_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_drive_o) |-> $past(store_done_i));
  assert_hold_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(disable_o) |-> $past(pin_high_i));
  assert_start_dirty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |-> $past(dirty_i || dirty_set_i));
endmodule

// File: rtl/nv_store_ctrl.sv
module nv_store_ctrl #(
  parameter int DELAY_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_pin_i,
  input  logic ce_i,
  input  logic we_i,
  input  logic rd_i,
  input  logic ext_store_i,
  input  logic store_done_i,
  input  logic recall_done_i,
  output logic busy_drive_o,
  output logic write_inhibit_o,
  output logic disable_o,
  output logic store_start_o,
  output logic write_grant_o,
  output logic read_grant_o
);
  logic pin_level, fall, pin_high;
  logic wr_req, dirty, dirty_set, store_end;

  // wired-AND of the external pin with the block's own pull-down
  assign pin_level = req_pin_i & ~busy_drive_o;
  assign wr_req    = ce_i & we_i;

  nvs_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (pin_level),
    .fall_o     (fall),
    .all_high_o (pin_high)
  );

  nvs_store_fsm #(.DELAY_CYCLES(DELAY_CYCLES)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .fall_i          (fall),
    .pin_high_i      (pin_high),
    .ext_store_i     (ext_store_i),
    .store_done_i    (store_done_i),
    .wr_req_i        (wr_req),
    .dirty_i         (dirty),
    .dirty_set_i     (dirty_set),
    .busy_drive_o    (busy_drive_o),
    .disable_o       (disable_o),
    .write_inhibit_o (write_inhibit_o),
    .store_start_o   (store_start_o),
    .store_end_o     (store_end)
  );

  nvs_dirty_track u_dirty (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_grant_i (write_grant_o),
    .clear_i    (store_end | recall_done_i),
    .dirty_o    (dirty),
    .set_o      (dirty_set)
  );

  assign write_grant_o = wr_req & ~write_inhibit_o & ~disable_o;
  assign read_grant_o  = ce_i & rd_i & ~disable_o;

  assert_no_write_in_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_drive_o |-> write_inhibit_o);
  assert_ext_no_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_drive_o) && !store_start_o |-> $past(ext_store_i));
endmodule

// File: tb/test_nv_store_ctrl.sv
module test_nv_store_ctrl;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_pin = 1'b1, ce = 1'b0, we = 1'b0, rd = 1'b0;
  logic ext_store = 1'b0, store_done = 1'b0, recall_done = 1'b0;
  logic busy, inhibit, dis, start, wgrant, rgrant;
  int checks = 0, errors = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  nv_store_ctrl #(.DELAY_CYCLES(D)) i_nv_store_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_pin_i(req_pin), .ce_i(ce), .we_i(we), .rd_i(rd),
    .ext_store_i(ext_store), .store_done_i(store_done), .recall_done_i(recall_done),
    .busy_drive_o(busy), .write_inhibit_o(inhibit), .disable_o(dis),
    .store_start_o(start), .write_grant_o(wgrant), .read_grant_o(rgrant)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_write();
    ce = 1'b1; we = 1'b1; tick(1);
    ce = 1'b0; we = 1'b0; tick(1);
  endtask

  // finish a running store and wait out the release of the pin
  task automatic finish_store(input string tag);
    store_done = 1'b1; tick(1); store_done = 1'b0;
    chk({tag, " busy released"}, busy, 1'b0);
    req_pin = 1'b1; tick(3);
    chk({tag, " disable held"}, dis, 1'b1);
    tick(1);
    chk({tag, " disable released"}, dis, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    tick(2); rst_n = 1'b1; tick(1);
    // R1
    chk("R1 busy", busy, 1'b0); chk("R1 inhibit", inhibit, 1'b0);
    chk("R1 disable", dis, 1'b0); chk("R1 start", start, 1'b0);

    // R2: exhaustive strobe combinations with pin released
    for (int v = 0; v < 8; v++) begin
      ce = v[0]; we = v[1]; rd = v[2]; #1;
      chk("R2 write grant", wgrant, v[0] & v[1]);
      chk("R2 read grant", rgrant, v[0] & v[2]);
      tick(1);
    end
    ce = 1'b0; we = 1'b0; rd = 1'b0; tick(6);
    chk("R2 no store", busy | start, 1'b0);

    // R3/R4/R5/R7/R8: dirty from R2 writes
    req_pin = 1'b0; tick(2);
    chk("R3 inhibit not yet", inhibit, 1'b0);
    tick(1);
    chk("R3 inhibit", inhibit, 1'b1);
    ce = 1'b1; rd = 1'b1; #1;
    chk("R3 read in window", rgrant, 1'b1);
    rd = 1'b0; we = 1'b1; #1;
    chk("R4 new write refused", wgrant, 1'b0);
    ce = 1'b0; we = 1'b0;
    tick(D - 1);
    chk("R5 busy not early", busy, 1'b0);
    tick(1);
    chk("R5 busy", busy, 1'b1); chk("R5 start", start, 1'b1); chk("R5 disable", dis, 1'b1);
    tick(1);
    chk("R5 start one cycle", start, 1'b0);
    tick(3);
    chk("R7 busy held", busy, 1'b1);
    store_done = 1'b1; tick(1); store_done = 1'b0;
    chk("R7 busy drop", busy, 1'b0); chk("R8 disable kept", dis, 1'b1);
    tick(2);
    chk("R8 disable while pin low", dis, 1'b1);
    req_pin = 1'b1; tick(3);
    chk("R8 disable 3 edges", dis, 1'b1);
    tick(1);
    chk("R8 disable release", dis, 1'b0); chk("R8 inhibit release", inhibit, 1'b0);

    // R6/R9: no write since store
    req_pin = 1'b0; tick(3 + D);
    chk("R6 no start", start, 1'b0); chk("R6 no busy", busy, 1'b0);
    chk("R6 no disable", dis, 1'b0); chk("R6 inhibit", inhibit, 1'b1);
    ce = 1'b1; we = 1'b1; #1;
    chk("R6 write refused", wgrant, 1'b0);
    ce = 1'b0; we = 1'b0;
    tick(5);
    chk("R9 clean no store", start | busy, 1'b0);
    req_pin = 1'b1; tick(3);
    chk("R6 inhibit held", inhibit, 1'b1);
    tick(1);
    chk("R6 inhibit release", inhibit, 1'b0);

    // R4/R9 sweep: carried write ending at each point of the window
    for (int l = 1; l < D; l++) begin
      recall_done = 1'b1; tick(1); recall_done = 1'b0;
      ce = 1'b1; we = 1'b1; tick(1);
      req_pin = 1'b0; tick(3);
      chk("R4 carried write granted", wgrant, 1'b1);
      tick(l);
      chk("R4 carried write still granted", wgrant, 1'b1);
      ce = 1'b0; we = 1'b0; tick(1);
      ce = 1'b1; we = 1'b1; #1;
      chk("R4 rewrite refused", wgrant, 1'b0);
      ce = 1'b0; we = 1'b0;
      tick(D - l - 1);
      chk("R9 carried write makes dirty", start, 1'b1);
      finish_store("R9 sweep");
    end

    // R9: recall clears dirty
    do_write();
    recall_done = 1'b1; tick(1); recall_done = 1'b0;
    req_pin = 1'b0; tick(3 + D);
    chk("R9 recall cleared", start | busy, 1'b0);
    req_pin = 1'b1; tick(4);

    // R12: done outside store ignored
    do_write();
    store_done = 1'b1; tick(1); store_done = 1'b0;
    chk("R12 busy", busy, 1'b0); chk("R12 disable", dis, 1'b0); chk("R12 inhibit", inhibit, 1'b0);
    req_pin = 1'b0; tick(3 + D);
    chk("R12 dirty kept", start, 1'b1);
    finish_store("R12");

    // R10/R11: store from another source
    do_write();
    ext_store = 1'b1; tick(1); ext_store = 1'b0;
    chk("R10 busy", busy, 1'b1); chk("R10 disable", dis, 1'b1);
    chk("R10 inhibit", inhibit, 1'b1); chk("R10 no start", start, 1'b0);
    tick(3);
    ext_store = 1'b1; tick(1); ext_store = 1'b0;
    chk("R10 busy held", busy, 1'b1);
    finish_store("R10");
    tick(8);
    chk("R11 no self request", inhibit | busy | dis, 1'b0);
    req_pin = 1'b0; tick(3 + D);
    chk("R10 store cleared dirty", start | busy, 1'b0);
    req_pin = 1'b1; tick(4);
    chk("R6 back to idle", inhibit, 1'b0);

    report();
  end
endmodule